// File: doc/BRIEF.md
# Thread Interrupt Priority Presenter

This block holds the interrupt management state of one hardware thread. The state is split into four separate rings: physical (ring 0, most privileged), hypervisor (ring 1), operating system (ring 2) and user (ring 3). Each ring keeps three things:
- an eight-bit pending buffer with one bit per priority level;
- a current processor priority (CPPR);
- a notification source register whose bit 7 is the exception-outstanding flag.

The most favoured pending priority is derived from the pending buffer. A lower number is more favoured, and 0xFF means nothing is pending.

An upstream routing stage sends notify pulses, each carrying a ring and a priority. Software reaches the rings through a single register port. On that port, the two-bit page index of the access is the privilege view, and a separate ring field picks the ring being addressed. The block compares the most favoured pending priority with the CPPR of each ring and drives one interrupt line per ring. Software takes an interrupt with an acknowledge load. It can also move its priority threshold with a CPPR store.

Top module: `thread_prio_presenter`

## Requirements
- R1: After reset, every pending buffer is empty, every CPPR is 0x00, every interrupt line is low, and `acc_rvalid` is low.
- R2: A notify pulse sets bit `ntf_prio` of the pending buffer of ring `ntf_ring`. The change is visible to a status read made in the following cycle.
- R3: A status read (register select 2) returns the pending buffer in bits 15:8 and the most favoured pending priority in bits 7:0. That priority is the lowest set bit index, or 0xFF when the buffer is empty.
- R4: `irq_out[r]` is high exactly when, one cycle earlier, ring r had a most favoured pending priority numerically below its CPPR and no acknowledge was taken.
- R5: A write with register select 0 stores `acc_wdata` into the CPPR of the addressed ring. The interrupt line of that ring is re-evaluated against the new value on the next cycle, so the write may raise the line or lower it. A read with register select 0 returns the CPPR in bits 7:0 and zero in bits 15:8.
- R6: An acknowledge load (register select 1, read) on a ring whose interrupt line is high has the following effects:
  - it returns the notification source register in bits 15:8 (0x80) and the old CPPR in bits 7:0;
  - it sets CPPR to the pending priority;
  - it clears that pending bit;
  - it lowers the line on the next cycle.
- R7: An acknowledge load on a ring whose line is low returns 0x00 and the CPPR, and changes no state.
- R8: The view given by `acc_page` may reach only rings whose number is greater than or equal to the view. Any access to a more privileged ring reads as zero, and the block ignores it as a store and as an acknowledge.
- R9: A notify or access aimed at one ring leaves the other rings' buffers, CPPRs and lines unchanged.
- R10: When a notify and an acknowledge hit the same ring and priority in the same cycle, the pending bit stays set.
- R11: Every read returns its data with `acc_rvalid` high exactly one cycle after the request. Writes raise no `acc_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ntf_valid | input | 1 | Notify pulse |
| ntf_ring | input | 2 | Ring of the notification |
| ntf_prio | input | 3 | Priority of the notification |
| acc_valid | input | 1 | Register access request |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_page | input | 2 | Page index low bits: privilege view (0 physical … 3 user) |
| acc_ring | input | 2 | Ring addressed by the access |
| acc_reg | input | 2 | Register select: 0 CPPR, 1 acknowledge, 2 status, 3 reads zero |
| acc_wdata | input | 8 | Store data |
| acc_rdata | output | 16 | Load data |
| acc_rvalid | output | 1 | Load data valid |
| irq_out | output | 4 | Interrupt line per ring |

## Verification
Each result has a fixed latency. A notify lands in the pending buffer at the first edge after it is driven, and the interrupt line follows one edge later. A CPPR store or an acknowledge changes its ring's state at the first edge, and the line responds at the second. Load data appears at the first edge. The bench drives inputs on falling edges. It samples load data at the falling edge right after the request, and it samples interrupt lines one further falling edge later. This means every check falls inside the cycle its requirement names. The bench sweeps all ring, priority and threshold combinations.

// File: rtl/tpp_pkg.sv
package tpp_pkg;
    localparam int unsigned RINGS   = 4;
    localparam int unsigned NPRIO   = 8;
    localparam int unsigned PRW     = 8;
    localparam int unsigned RING_W  = $clog2(RINGS);
    localparam int unsigned PIDX_W  = $clog2(NPRIO);
    localparam int unsigned DATA_W  = 2 * PRW;
    localparam logic [PRW-1:0] PRIO_NONE = '1;

    typedef enum logic [1:0] {
        SEL_CPPR = 2'd0,
        SEL_ACK  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_RSVD = 2'd3
    } reg_sel_e;

    // most favoured (lowest index) pending priority, PRIO_NONE if empty
    function automatic logic [PRW-1:0] pipr_of(input logic [NPRIO-1:0] buf_in);
        logic [PRW-1:0] res;
        res = PRIO_NONE;
        for (int i = NPRIO - 1; i >= 0; i--) begin
            if (buf_in[i]) res = PRW'(i);
        end
        return res;
    endfunction

    function automatic logic view_allows(input logic [RING_W-1:0] view,
                                         input logic [RING_W-1:0] ring);
        return ring >= view;
    endfunction
endpackage

// File: rtl/tpp_ring_ctx.sv
module tpp_ring_ctx
    import tpp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              set_vld,
    input  logic [PIDX_W-1:0] set_prio,
    input  logic              cppr_we,
    input  logic [PRW-1:0]    cppr_wdata,
    input  logic              ack_req,
    output logic [NPRIO-1:0]  ipb,
    output logic [PRW-1:0]    cppr,
    output logic [PRW-1:0]    pipr,
    output logic              eo
);
    logic [NPRIO-1:0] ipb_q, set_mask, clr_mask;
    logic [PRW-1:0]   cppr_q;
    logic             eo_q, ack_hit;

    assign pipr    = pipr_of(ipb_q);
    assign ack_hit = ack_req && eo_q;

    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        if (set_vld) set_mask[set_prio] = 1'b1;
        if (ack_hit) clr_mask[pipr[PIDX_W-1:0]] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ipb_q  <= '0;
            cppr_q <= '0;
            eo_q   <= 1'b0;
        end else begin
            ipb_q <= (ipb_q & ~clr_mask) | set_mask;
            if (ack_hit)      cppr_q <= pipr;
            else if (cppr_we) cppr_q <= cppr_wdata;
            eo_q <= ack_hit ? 1'b0 : (pipr < cppr_q);
        end
    end

    assign ipb  = ipb_q;
    assign cppr = cppr_q;
    assign eo   = eo_q;
endmodule

// File: rtl/tpp_access_port.sv
module tpp_access_port
    import tpp_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        acc_valid,
    input  logic                        acc_write,
    input  logic [RING_W-1:0]           acc_page,
    input  logic [RING_W-1:0]           acc_ring,
    input  logic [1:0]                  acc_reg,
    input  logic [RINGS-1:0][NPRIO-1:0] ipb,
    input  logic [RINGS-1:0][PRW-1:0]   cppr,
    input  logic [RINGS-1:0][PRW-1:0]   pipr,
    input  logic [RINGS-1:0]            eo,
    output logic [RINGS-1:0]            cppr_we,
    output logic [RINGS-1:0]            ack_req,
    output logic [DATA_W-1:0]           rdata,
    output logic                        rvalid
);
    logic        allowed;
    reg_sel_e    sel;
    logic [DATA_W-1:0] rd_comb;

    assign allowed = view_allows(acc_page, acc_ring);
    assign sel     = reg_sel_e'(acc_reg);

    for (genvar r = 0; r < RINGS; r++) begin : g_dec
        logic hit;
        assign hit        = acc_valid && allowed && (acc_ring == RING_W'(r));
        assign cppr_we[r] = hit && acc_write && (sel == SEL_CPPR);
        assign ack_req[r] = hit && !acc_write && (sel == SEL_ACK);
    end

    always_comb begin
        rd_comb = '0;
        if (allowed) begin
            unique case (sel)
                SEL_CPPR: rd_comb = {{PRW{1'b0}}, cppr[acc_ring]};
                SEL_ACK:  rd_comb = {eo[acc_ring], {(PRW-1){1'b0}}, cppr[acc_ring]};
                SEL_STAT: rd_comb = {PRW'(ipb[acc_ring]), pipr[acc_ring]};
                default:  rd_comb = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= acc_valid && !acc_write;
            if (acc_valid && !acc_write) rdata <= rd_comb;
        end
    end
endmodule

// File: rtl/thread_prio_presenter.sv
module thread_prio_presenter
    import tpp_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ntf_valid,
    input  logic [RING_W-1:0]        ntf_ring,
    input  logic [PIDX_W-1:0]        ntf_prio,
    input  logic                     acc_valid,
    input  logic                     acc_write,
    input  logic [RING_W-1:0]        acc_page,
    input  logic [RING_W-1:0]        acc_ring,
    input  logic [1:0]               acc_reg,
    input  logic [PRW-1:0]           acc_wdata,
    output logic [DATA_W-1:0]        acc_rdata,
    output logic                     acc_rvalid,
    output logic [RINGS-1:0]         irq_out
);
    logic [RINGS-1:0][NPRIO-1:0] ipb_all;
    logic [RINGS-1:0][PRW-1:0]   cppr_all, pipr_all;
    logic [RINGS-1:0]            eo_all, cppr_we, ack_req;

    for (genvar r = 0; r < RINGS; r++) begin : g_ring
        tpp_ring_ctx u_ctx (
            .clk        (clk),
            .rst        (rst),
            .set_vld    (ntf_valid && (ntf_ring == RING_W'(r))),
            .set_prio   (ntf_prio),
            .cppr_we    (cppr_we[r]),
            .cppr_wdata (acc_wdata),
            .ack_req    (ack_req[r]),
            .ipb        (ipb_all[r]),
            .cppr       (cppr_all[r]),
            .pipr       (pipr_all[r]),
            .eo         (eo_all[r])
        );
    end

    tpp_access_port u_port (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_page  (acc_page),
        .acc_ring  (acc_ring),
        .acc_reg   (acc_reg),
        .ipb       (ipb_all),
        .cppr      (cppr_all),
        .pipr      (pipr_all),
        .eo        (eo_all),
        .cppr_we   (cppr_we),
        .ack_req   (ack_req),
        .rdata     (acc_rdata),
        .rvalid    (acc_rvalid)
    );

    assign irq_out = eo_all;
endmodule

// File: rtl/tpp_checker.sv
module tpp_checker
    import tpp_pkg::*;
(
    input logic                        clk,
    input logic                        rst,
    input logic                        ntf_valid,
    input logic [RING_W-1:0]           ntf_ring,
    input logic [PIDX_W-1:0]           ntf_prio,
    input logic                        acc_valid,
    input logic                        acc_write,
    input logic [RING_W-1:0]           acc_page,
    input logic [RING_W-1:0]           acc_ring,
    input logic [1:0]                  acc_reg,
    input logic [DATA_W-1:0]           acc_rdata,
    input logic                        acc_rvalid,
    input logic [RINGS-1:0]            irq_out,
    input logic [RINGS-1:0][NPRIO-1:0] ipb_all
);
    logic ack_live;
    assign ack_live = acc_valid && !acc_write && (acc_reg == 2'd1)
                      && (acc_ring >= acc_page) && irq_out[acc_ring];

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (irq_out == '0 && !acc_rvalid));

    a_r2_notify_sets: assert property (@(posedge clk) disable iff (rst)
        ntf_valid |=> ipb_all[$past(ntf_ring)][$past(ntf_prio)]);

    a_r6_ack_drops_line: assert property (@(posedge clk) disable iff (rst)
        ack_live |=> !irq_out[$past(acc_ring)]);

    a_r6_ack_reports_eo: assert property (@(posedge clk) disable iff (rst)
        ack_live |=> acc_rdata[DATA_W-1]);

    a_r8_priv_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && acc_ring < acc_page) |=> acc_rdata == '0);

    a_r11_rvalid_follows_read: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write) |=> acc_rvalid);

    a_r11_no_rvalid_otherwise: assert property (@(posedge clk) disable iff (rst)
        !(acc_valid && !acc_write) |=> !acc_rvalid);
endmodule

bind thread_prio_presenter tpp_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .ntf_valid  (ntf_valid),
    .ntf_ring   (ntf_ring),
    .ntf_prio   (ntf_prio),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_page   (acc_page),
    .acc_ring   (acc_ring),
    .acc_reg    (acc_reg),
    .acc_rdata  (acc_rdata),
    .acc_rvalid (acc_rvalid),
    .irq_out    (irq_out),
    .ipb_all    (ipb_all)
);

// File: tb/thread_prio_presenter_tb.sv
`timescale 1ns/1ps
module thread_prio_presenter_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ntf_valid = 1'b0;
    logic [1:0]  ntf_ring = '0;
    logic [2:0]  ntf_prio = '0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [1:0]  acc_page = '0;
    logic [1:0]  acc_ring = '0;
    logic [1:0]  acc_reg = '0;
    logic [7:0]  acc_wdata = '0;
    logic [15:0] acc_rdata;
    logic        acc_rvalid;
    logic [3:0]  irq_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    thread_prio_presenter u_dut (
        .clk(clk), .rst(rst),
        .ntf_valid(ntf_valid), .ntf_ring(ntf_ring), .ntf_prio(ntf_prio),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_page(acc_page),
        .acc_ring(acc_ring), .acc_reg(acc_reg), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_rvalid(acc_rvalid), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic notify(input logic [1:0] r, input logic [2:0] p);
        @(negedge clk);
        ntf_valid = 1'b1; ntf_ring = r; ntf_prio = p;
        @(negedge clk);
        ntf_valid = 1'b0;
    endtask

    task automatic access(input logic [1:0] view, input logic [1:0] r, input logic [1:0] sel,
                          input bit wr, input logic [7:0] wd, output logic [15:0] rd);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_page = view; acc_ring = r;
        acc_reg = sel; acc_wdata = wd;
        @(negedge clk);
        rd = acc_rdata;
        chk("R11 rvalid", 16'(acc_rvalid), 16'(!wr));
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    function automatic logic [7:0] lowest(input logic [7:0] b);
        for (int i = 0; i < 8; i++) if (b[i]) return 8'(i);
        return 8'hFF;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        logic [7:0]  b;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 irq", 16'(irq_out), 16'h0);
        chk("R1 rvalid", 16'(acc_rvalid), 16'h0);
        for (int r = 0; r < 4; r++) begin
            access(2'd0, 2'(r), 2'd2, 1'b0, 8'h0, rd);
            chk("R1 R3 empty status", rd, 16'h00FF);
            access(2'd0, 2'(r), 2'd0, 1'b0, 8'h0, rd);
            chk("R1 cppr", rd, 16'h0000);
        end

        // Exhaustive sweep: ring x priority x threshold (R2 R3 R4 R5 R6 R9)
        for (int r = 0; r < 4; r++) begin
            for (int p = 0; p < 8; p++) begin
                for (int ci = 0; ci < 9; ci++) begin
                    logic [7:0] c;
                    c = (ci == 8) ? 8'hFF : 8'(ci);
                    access(2'd0, 2'(r), 2'd0, 1'b1, c, rd);
                    access(2'd0, 2'(r), 2'd0, 1'b0, 8'h0, rd);
                    chk("R5 cppr readback", rd, {8'h00, c});
                    notify(2'(r), 3'(p));
                    access(2'd0, 2'(r), 2'd2, 1'b0, 8'h0, rd);
                    chk("R2 R3 status", rd, {8'(1 << p), 8'(p)});
                    chk("R4 R9 irq", 16'(irq_out), 16'((8'(p) < c) ? (1 << r) : 0));
                    if (!(8'(p) < c)) begin
                        access(2'd0, 2'(r), 2'd0, 1'b1, 8'hFF, rd);
                        idle();
                        chk("R5 store raises", 16'(irq_out), 16'(1 << r));
                        c = 8'hFF;
                    end
                    access(2'd0, 2'(r), 2'd1, 1'b0, 8'h0, rd);
                    chk("R6 ack data", rd, {8'h80, c});
                    idle();
                    chk("R6 line low", 16'(irq_out), 16'h0);
                    access(2'd0, 2'(r), 2'd2, 1'b0, 8'h0, rd);
                    chk("R6 bit cleared", rd, 16'h00FF);
                    access(2'd0, 2'(r), 2'd0, 1'b0, 8'h0, rd);
                    chk("R6 cppr from pipr", rd, {8'h00, 8'(p)});
                end
            end
        end

        // Multi-bit ordering on ring 2 (R3 R6)
        b = 8'b0110_0100;
        notify(2'd2, 3'd5); notify(2'd2, 3'd2); notify(2'd2, 3'd6);
        for (int k = 0; k < 3; k++) begin
            access(2'd2, 2'd2, 2'd2, 1'b0, 8'h0, rd);
            chk("R3 multi status", rd, {b, lowest(b)});
            access(2'd2, 2'd2, 2'd0, 1'b1, 8'hFF, rd);
            idle();
            access(2'd2, 2'd2, 2'd1, 1'b0, 8'h0, rd);
            chk("R6 ack in order", rd, 16'h80FF);
            b[lowest(b)] = 1'b0;
        end
        access(2'd2, 2'd2, 2'd2, 1'b0, 8'h0, rd);
        chk("R3 drained", rd, 16'h00FF);

        // R7: ack while line low changes nothing
        access(2'd1, 2'd1, 2'd0, 1'b1, 8'h03, rd);
        notify(2'd1, 3'd4);
        idle();
        access(2'd1, 2'd1, 2'd1, 1'b0, 8'h0, rd);
        chk("R7 ack idle data", rd, 16'h0003);
        access(2'd1, 2'd1, 2'd2, 1'b0, 8'h0, rd);
        chk("R7 state kept", rd, 16'h1004);

        // R8: privilege; ring 1 CPPR=3, bit 4 pending
        access(2'd2, 2'd1, 2'd0, 1'b1, 8'hFF, rd);
        access(2'd0, 2'd1, 2'd0, 1'b0, 8'h0, rd);
        chk("R8 store ignored", rd, 16'h0003);
        idle();
        chk("R8 line untouched", 16'(irq_out), 16'h0);
        access(2'd3, 2'd1, 2'd2, 1'b0, 8'h0, rd);
        chk("R8 read zero", rd, 16'h0000);
        access(2'd1, 2'd1, 2'd0, 1'b1, 8'hFF, rd);
        idle();
        chk("R8 own ring ok", 16'(irq_out), 16'h2);
        access(2'd2, 2'd1, 2'd1, 1'b0, 8'h0, rd);
        chk("R8 ack blocked data", rd, 16'h0000);
        idle();
        chk("R8 ack blocked line", 16'(irq_out), 16'h2);
        access(2'd1, 2'd1, 2'd1, 1'b0, 8'h0, rd);
        chk("R6 ack allowed", rd, 16'h80FF);
        access(2'd0, 2'd0, 2'd3, 1'b0, 8'h0, rd);
        chk("R8 reserved reads zero", rd, 16'h0000);

        // R10: notify and ack collide on ring 3 priority 1
        access(2'd3, 2'd3, 2'd0, 1'b1, 8'hFF, rd);
        notify(2'd3, 3'd1);
        idle();
        chk("R10 setup line", 16'(irq_out), 16'h8);
        @(negedge clk);
        ntf_valid = 1'b1; ntf_ring = 2'd3; ntf_prio = 3'd1;
        acc_valid = 1'b1; acc_write = 1'b0; acc_page = 2'd3; acc_ring = 2'd3; acc_reg = 2'd1;
        @(negedge clk);
        chk("R10 ack data", acc_rdata, 16'h80FF);
        ntf_valid = 1'b0; acc_valid = 1'b0;
        access(2'd3, 2'd3, 2'd2, 1'b0, 8'h0, rd);
        chk("R10 bit kept", rd, 16'h0201);
        chk("R10 line low", 16'(irq_out), 16'h0);
        access(2'd3, 2'd3, 2'd0, 1'b1, 8'hFF, rd);
        idle();
        chk("R5 R10 line again", 16'(irq_out), 16'h8);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule